// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date as six packed BCD byte registers: seconds, minutes, hours (24-hour only), day of month, month (1 to 12) and a two-digit year (00 to 99, meaning 2000 to 2099). A tick enable at the oscillator rate, nominally 32768 Hz, drives a sub-second prescaler. When the counter is running, the prescaler advances the calendar once per second. The calendar handles month lengths and leap Februaries.

Software reaches every register through a byte-wide register port. Writes are synchronous and reads are combinational. A status register reports a busy window just before each update, the run state, and sticky write-one-to-clear flags for second, minute, hour and day events and for an alarm match. The alarm matches only when all six alarm fields equal the new time; no field can be masked. Two interrupt outputs are provided. One is a one-cycle periodic pulse per second. The other is the alarm flag gated by its enable.

Top module: `rtc_bcd_cal`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. The alarm fields hold the same values. Control, status and interrupt enable read 0x00, and both interrupt outputs are low.
- R2: Time fields sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. Alarm fields use the same order at 0x20 to 0x34. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Written values read back, and any other address reads 0x00.
- R3: Control bit 0 set makes the clock run and clear stops it. Control bit 3 (12/24-hour select) and all other control bits read 0. While running, one update occurs every TICKS_PER_SEC cycles with tick_i high. While stopped, time does not advance. Status bit 1 mirrors the run bit.
- R4: Seconds and minutes wrap from 59 to 00 and carry into the next field. Hours wrap from 23 to 00 and carry into the day.
- R5: Day wraps to 01 after 31, 30 or 28/29 days depending on the month, with February at 29 when the binary year is divisible by 4. Month wraps from 12 to 01 and carries into the year. Year wraps from 99 to 00.
- R6: Status bit 0 (busy) is high while running during the last tick interval before each update. It is low in the cycle after the update and whenever the clock is stopped.
- R7: On each update, status bit 2 is set. Bit 3 is set when seconds wrap, bit 4 when minutes also wrap, and bit 5 when hours also wrap. Each bit stays set until a 1 is written to it at 0x44. Writing 0 has no effect.
- R8: Status bit 6 is set in the cycle after an update whose new time equals the alarm in all six fields. A mismatch in any single field prevents it. The bit is cleared by writing 1 to it.
- R9: With interrupt enable bit 2 set, irq_timer_o is high for exactly one cycle after each update, in the cycle the new time first reads back. With bit 2 clear, irq_timer_o stays low.
- R10: irq_alarm_o is high exactly while status bit 6 and interrupt enable bit 3 are both set.
- R11: A write to a time field while running shows in the next cycle. It does not reset the prescaler, so the following update keeps its original spacing from the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oscillator-rate tick enable |
| addr_i | input | ADDR_W | Register byte address |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_timer_o | output | 1 | One-cycle pulse per second when enabled |
| irq_alarm_o | output | 1 | Alarm flag gated by its enable |

## Verification
The clock is run continuously for over two hours of simulated seconds across a midnight that ends a non-leap February. Every update is compared field by field with a binary reference, together with the event flags, which separates errors in the carry chain from errors in the flags. A sweep sets 23:59:59 on the last day of each month over leap, non-leap and wrap-around years, which isolates month-length and year-carry faults. Alarm tests use an exact match and six near matches, each differing in one field, to catch any comparator that ignores a field. Prescaler phase, busy placement and tick gaps are measured as cycle distances between timer pulses.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FLD_SEC  = 0;
  localparam int FLD_MIN  = 1;
  localparam int FLD_HOUR = 2;
  localparam int FLD_DAY  = 3;
  localparam int FLD_MON  = 4;
  localparam int FLD_YEAR = 5;

  localparam int TIME_BASE  = 'h00;
  localparam int ALARM_BASE = 'h20;
  localparam int CTRL_ADDR  = 'h40;
  localparam int STAT_ADDR  = 'h44;
  localparam int IEN_ADDR   = 'h48;

  typedef logic [7:0] bcd_t;
  typedef logic [NUM_FIELDS-1:0][7:0] fields_t;

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] bcd_to_bin(input bcd_t v);
    return {4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]};
  endfunction

  function automatic bcd_t last_day(input bcd_t mon, input bcd_t yr);
    case (mon)
      8'h02:                      return ((bcd_to_bin(yr) % 8'd4) == 8'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t field_reset(input int f);
    return (f == FLD_DAY || f == FLD_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic busy_o,
  output logic sec_stb_o
);
  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TICKS_PER_SEC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last      = (cnt_q == CNT_MAX);
  assign busy_o    = run_i & last;
  assign sec_stb_o = run_i & tick_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sec_stb_i,
  input  logic [NUM_FIELDS-1:0] we_i,
  input  logic [7:0]            wdata_i,
  output fields_t               time_o,
  output logic [2:0]            evt_o      // {day, hour, min} carries
);
  fields_t nxt;
  logic sec_wrap, min_wrap, hour_wrap, day_wrap, mon_wrap;

  always_comb begin
    sec_wrap  = time_o[FLD_SEC] == 8'h59;
    min_wrap  = sec_wrap & (time_o[FLD_MIN] == 8'h59);
    hour_wrap = min_wrap & (time_o[FLD_HOUR] == 8'h23);
    day_wrap  = hour_wrap & (time_o[FLD_DAY] >= last_day(time_o[FLD_MON], time_o[FLD_YEAR]));
    mon_wrap  = day_wrap & (time_o[FLD_MON] >= 8'h12);

    nxt[FLD_SEC]  = sec_wrap ? 8'h00 : bcd_inc(time_o[FLD_SEC]);
    nxt[FLD_MIN]  = !sec_wrap  ? time_o[FLD_MIN]  : (min_wrap  ? 8'h00 : bcd_inc(time_o[FLD_MIN]));
    nxt[FLD_HOUR] = !min_wrap  ? time_o[FLD_HOUR] : (hour_wrap ? 8'h00 : bcd_inc(time_o[FLD_HOUR]));
    nxt[FLD_DAY]  = !hour_wrap ? time_o[FLD_DAY]  : (day_wrap  ? 8'h01 : bcd_inc(time_o[FLD_DAY]));
    nxt[FLD_MON]  = !day_wrap  ? time_o[FLD_MON]  : (mon_wrap  ? 8'h01 : bcd_inc(time_o[FLD_MON]));
    nxt[FLD_YEAR] = !mon_wrap  ? time_o[FLD_YEAR] :
                    ((time_o[FLD_YEAR] == 8'h99) ? 8'h00 : bcd_inc(time_o[FLD_YEAR]));
  end

  assign evt_o = {hour_wrap, min_wrap, sec_wrap};

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    bcd_t fld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        fld_q <= field_reset(f);
      else if (we_i[f])   fld_q <= wdata_i;      // software wins over the update
      else if (sec_stb_i) fld_q <= nxt[f];
    end
    assign time_o[f] = fld_q;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  fields_t time_i,
  input  fields_t alarm_i,
  output logic    match_o
);
  logic [NUM_FIELDS-1:0] eq;
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_eq
    assign eq[f] = time_i[f] == alarm_i[f];
  end
  assign match_o = &eq;
endmodule

// File: rtl/rtc_bcd_cal.sv
module rtc_bcd_cal
  import rtc_cal_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int ADDR_W        = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              irq_timer_o,
  output logic              irq_alarm_o
);
  logic                  run_q, busy, sec_stb, upd_q, match;
  logic [1:0]            ien_q;     // [0] periodic, [1] alarm
  logic [6:2]            stat_q;
  logic [6:2]            stat_set;
  logic [2:0]            evt;
  fields_t               time_q, alarm_q;
  logic [NUM_FIELDS-1:0] time_we, alarm_we;
  logic                  ctrl_we, stat_we, ien_we;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_regs
    bcd_t alm_q;
    assign time_we[f]  = wr_i & hit(addr_i, TIME_BASE + 4 * f);
    assign alarm_we[f] = wr_i & hit(addr_i, ALARM_BASE + 4 * f);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         alm_q <= field_reset(f);
      else if (alarm_we[f]) alm_q <= wdata_i;
    end
    assign alarm_q[f] = alm_q;
  end

  assign ctrl_we = wr_i & hit(addr_i, CTRL_ADDR);
  assign stat_we = wr_i & hit(addr_i, STAT_ADDR);
  assign ien_we  = wr_i & hit(addr_i, IEN_ADDR);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) i_prescaler (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .tick_i    (tick_i),
    .busy_o    (busy),
    .sec_stb_o (sec_stb)
  );

  rtc_calendar i_calendar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sec_stb_i (sec_stb),
    .we_i      (time_we),
    .wdata_i   (wdata_i),
    .time_o    (time_q),
    .evt_o     (evt)
  );

  rtc_alarm_match i_alarm (
    .time_i  (time_q),
    .alarm_i (alarm_q),
    .match_o (match)
  );

  assign stat_set = {upd_q & match, sec_stb & evt[2], sec_stb & evt[1], sec_stb & evt[0], sec_stb};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ien_q  <= '0;
      upd_q  <= 1'b0;
      stat_q <= '0;
    end else begin
      if (ctrl_we) run_q <= wdata_i[0];
      if (ien_we)  ien_q <= wdata_i[3:2];
      upd_q  <= sec_stb;
      // set beats a same-cycle clear
      stat_q <= stat_set | (stat_q & ~(stat_we ? wdata_i[6:2] : 5'b0));
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (hit(addr_i, TIME_BASE + 4 * f))  rdata_o = time_q[f];
      if (hit(addr_i, ALARM_BASE + 4 * f)) rdata_o = alarm_q[f];
    end
    if (hit(addr_i, CTRL_ADDR)) rdata_o = {7'd0, run_q};
    if (hit(addr_i, STAT_ADDR)) rdata_o = {1'b0, stat_q, run_q, busy};
    if (hit(addr_i, IEN_ADDR))  rdata_o = {4'd0, ien_q, 2'd0};
  end

  assign irq_timer_o = upd_q & ien_q[0];
  assign irq_alarm_o = stat_q[6] & ien_q[1];
endmodule

// File: rtl/rtc_bcd_cal_chk.sv
module rtc_bcd_cal_chk
  import rtc_cal_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    busy,
  input logic    sec_stb,
  input logic    upd_q,
  input logic    run_q,
  input logic    wr_i,
  input logic    stat_alarm,
  input logic    stat_sec,
  input logic    irq_timer_o,
  input fields_t time_q
);
  // R6
  busy_low_after_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> !busy);

  // R8
  alarm_only_after_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_alarm) |-> $past(upd_q));

  // R9
  timer_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_timer_o |=> !irq_timer_o);

  // R3
  stopped_time_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(run_q) && !$past(wr_i)) |-> $stable(time_q));

  // R7
  sec_flag_from_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_sec) |-> $past(sec_stb));
endmodule

bind rtc_bcd_cal rtc_bcd_cal_chk i_rtc_bcd_cal_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy        (busy),
  .sec_stb     (sec_stb),
  .upd_q       (upd_q),
  .run_q       (run_q),
  .wr_i        (wr_i),
  .stat_alarm  (stat_q[6]),
  .stat_sec    (stat_q[2]),
  .irq_timer_o (irq_timer_o),
  .time_q      (time_q)
);

// File: tb/test_rtc_bcd_cal.sv
`timescale 1ns/1ps
module test_rtc_bcd_cal;
  localparam int TICKS = 4;
  localparam int A_CTRL = 'h40, A_STAT = 'h44, A_IEN = 'h48, A_ALM = 'h20;

  logic       clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, wr_i = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic       irq_timer_o, irq_alarm_o;
  logic       tick_gap = 1'b0;
  int         checks = 0, errors = 0, cyc = 0;

  rtc_bcd_cal #(.TICKS_PER_SEC(TICKS), .ADDR_W(8)) i_rtc_bcd_cal (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  initial forever begin
    @(negedge clk);
    tick_i = tick_gap ? ~tick_i : 1'b1;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr_i = 8'(a); wdata_i = 8'(d); wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr_i = 8'(a);
    #0.01;
    d = int'(rdata_o);
  endtask

  function automatic int bcd(input int v);
    return (v / 10) * 16 + v % 10;
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic longint pack(input int s, input int mi, input int h, input int d, input int mo, input int y);
    return {8'(bcd(y)), 8'(bcd(mo)), 8'(bcd(d)), 8'(bcd(h)), 8'(bcd(mi)), 8'(bcd(s))};
  endfunction

  task automatic read_fields(input int base, output longint v);
    int d;
    v = 0;
    for (int f = 5; f >= 0; f--) begin
      rd(base + 4 * f, d);
      v = (v << 8) | longint'(d);
    end
  endtask

  task automatic write_fields(input int base, input longint v);
    for (int f = 0; f < 6; f++) wr(base + 4 * f, int'((v >> (8 * f)) & 8'hFF));
  endtask

  task automatic wait_update(input string tag);
    bit ok = 0;
    for (int i = 0; i < 4 * TICKS + 4; i++) begin
      @(negedge clk);
      if (irq_timer_o) begin ok = 1; break; end
    end
    if (!ok) chk({tag, " update timeout"}, 0, 1);
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, st, c0, prev_busy, n;
    longint v;
    int s, mi, h, dy, mo, y;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_fields(0, v);      chk("R1 time", v, 48'h00_01_01_00_00_00);
    read_fields(A_ALM, v);  chk("R1 alarm", v, 48'h00_01_01_00_00_00);
    rd(A_CTRL, d);          chk("R1 ctrl", d, 0);
    rd(A_STAT, d);          chk("R1 status", d, 0);
    rd(A_IEN, d);           chk("R1 ien", d, 0);
    chk("R1 irq", {irq_timer_o, irq_alarm_o}, 0);

    // R2 map and readback
    write_fields(A_ALM, 48'h16_15_14_13_12_11);
    read_fields(A_ALM, v);  chk("R2 alarm readback", v, 48'h16_15_14_13_12_11);
    write_fields(0, pack(7, 8, 9, 10, 11, 12));
    read_fields(0, v);      chk("R2 time readback", v, pack(7, 8, 9, 10, 11, 12));
    rd('h3C, d);            chk("R2 unmapped", d, 0);
    rd('h4C, d);            chk("R2 unmapped", d, 0);
    wr(A_IEN, 'hFF); rd(A_IEN, d); chk("R2 ien bits", d, 'h0C);
    wr(A_IEN, 'h04);

    // R3 run control and rate
    wr(A_CTRL, 'h09); rd(A_CTRL, d); chk("R3 ctrl 24h only", d, 1);
    rd(A_STAT, d); chk("R3 run status", (d >> 1) & 1, 1);
    wait_update("R3");
    c0 = cyc; wait_update("R3"); chk("R3 update spacing", cyc - c0, TICKS);
    tick_gap = 1'b1;
    wait_update("R3"); c0 = cyc; wait_update("R3");
    chk("R3 spacing with tick gaps", cyc - c0, 2 * TICKS);
    tick_gap = 1'b0;
    wr(A_CTRL, 0);
    read_fields(0, v);
    n = 0;
    for (int i = 0; i < 4 * TICKS; i++) begin @(negedge clk); n += int'(irq_timer_o); end
    chk("R3 stopped no pulses", n, 0);
    begin longint v2; read_fields(0, v2); chk("R3 stopped time hold", v2, v); end
    rd(A_STAT, d); chk("R3 stopped run bit", (d >> 1) & 1, 0);

    // R6 busy placement
    for (int i = 0; i < 2 * TICKS; i++) begin
      @(negedge clk); rd(A_STAT, d); chk("R6 busy low when stopped", d & 1, 0);
    end
    wr(A_CTRL, 1);
    prev_busy = 0;
    for (int i = 0; i < 6 * TICKS; i++) begin
      @(negedge clk);
      rd(A_STAT, d);
      if (irq_timer_o) chk("R6 busy low after update", d & 1, 0);
      if (prev_busy == 1) chk("R6 busy precedes update", irq_timer_o, 1);
      if (irq_timer_o && i > 0) chk("R6 busy before update", prev_busy, 1);
      prev_busy = d & 1;
    end

    // R9 periodic interrupt
    n = 0;
    for (int i = 0; i < 4 * TICKS; i++) begin @(negedge clk); n += int'(irq_timer_o); end
    chk("R9 pulses per window", n, 4);
    wr(A_IEN, 0);
    n = 0;
    for (int i = 0; i < 4 * TICKS; i++) begin @(negedge clk); n += int'(irq_timer_o); end
    chk("R9 masked pulses", n, 0);
    wr(A_IEN, 'h04);

    // R11 write while running keeps prescaler phase
    wait_update("R11");
    c0 = cyc;
    wr(0, 'h30);
    rd(0, d); chk("R11 immediate write", d, 'h30);
    wait_update("R11");
    chk("R11 phase kept", cyc - c0, TICKS);
    rd(0, d); chk("R11 increment after write", d, 'h31);

    // R7 write-one-to-clear
    wr(A_CTRL, 0);
    @(negedge clk); @(negedge clk);
    rd(A_STAT, st); chk("R7 sec flag sticky", (st >> 2) & 1, 1);
    wr(A_STAT, 0);  rd(A_STAT, d); chk("R7 zero write no effect", d, st);
    wr(A_STAT, 'h04); rd(A_STAT, d); chk("R7 sec flag cleared", (d >> 2) & 1, 0);

    // R8 / R10 alarm exact match
    write_fields(0, pack(55, 34, 12, 15, 6, 24));
    write_fields(A_ALM, pack(57, 34, 12, 15, 6, 24));
    wr(A_IEN, 'h0C); wr(A_STAT, 'h7C); wr(A_CTRL, 1);
    wait_update("R8"); @(negedge clk);
    rd(A_STAT, d); chk("R8 no flag before match", (d >> 6) & 1, 0);
    wait_update("R8"); @(negedge clk);
    rd(A_STAT, d); chk("R8 flag on match", (d >> 6) & 1, 1);
    chk("R10 irq alarm on", irq_alarm_o, 1);
    wr(A_IEN, 'h04); chk("R10 irq alarm masked", irq_alarm_o, 0);
    wr(A_IEN, 'h0C); chk("R10 irq alarm unmasked", irq_alarm_o, 1);
    wr(A_STAT, 'h40);
    rd(A_STAT, d); chk("R8 flag W1C", (d >> 6) & 1, 0);
    chk("R10 irq alarm after clear", irq_alarm_o, 0);
    wait_update("R8"); @(negedge clk);
    rd(A_STAT, d); chk("R8 no re-match", (d >> 6) & 1, 0);

    // R8 single-field mismatch, each field
    for (int f = 0; f < 6; f++) begin
      wr(A_CTRL, 0);
      write_fields(0, pack(56, 34, 12, 15, 6, 24));
      write_fields(A_ALM, pack(57, 34, 12, 15, 6, 24) ^ (longint'(1) << (8 * f)));
      wr(A_STAT, 'h7C); wr(A_CTRL, 1);
      wait_update("R8"); @(negedge clk);
      rd(A_STAT, d); chk($sformatf("R8 mismatch field %0d", f), (d >> 6) & 1, 0);
      chk("R10 no irq on mismatch", irq_alarm_o, 0);
    end
    write_fields(A_ALM, pack(0, 0, 0, 1, 1, 98));

    // R5 end-of-month sweep
    foreach (y_list[k]) begin end
    for (int k = 0; k < 6; k++) begin
      y = (k < 4) ? k : ((k == 4) ? 24 : 99);
      for (int m = 1; m <= 12; m++) begin
        wr(A_CTRL, 0);
        write_fields(0, pack(59, 59, 23, days_in(m, y), m, y));
        wr(A_CTRL, 1);
        wait_update("R5");
        read_fields(0, v);
        chk($sformatf("R5 end of month %0d year %0d", m, y), v,
            pack(0, 0, 0, 1, (m == 12) ? 1 : m + 1, (m == 12) ? (y + 1) % 100 : y));
      end
    end
    wr(A_CTRL, 0);
    write_fields(0, pack(59, 59, 23, 28, 2, 24));
    wr(A_CTRL, 1); wait_update("R5"); read_fields(0, v);
    chk("R5 leap Feb 28 to 29", v, pack(0, 0, 0, 29, 2, 24));

    // R4 / R7 continuous sweep over midnight into March
    wr(A_CTRL, 0);
    s = 0; mi = 0; h = 22; dy = 28; mo = 2; y = 23;
    write_fields(0, pack(s, mi, h, dy, mo, y));
    wr(A_STAT, 'h7C);
    wr(A_CTRL, 1);
    for (int i = 0; i < 7300; i++) begin
      int exp_st;
      wait_update("R4");
      s++;
      if (s == 60) begin s = 0; mi++; end
      if (mi == 60) begin mi = 0; h++; end
      if (h == 24) begin
        h = 0; dy++;
        if (dy > days_in(mo, y)) begin dy = 1; mo++; end
        if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
      end
      read_fields(0, v);
      chk("R4 sweep time", v, pack(s, mi, h, dy, mo, y));
      exp_st = 'h02 | 'h04;
      if (s == 0) exp_st |= 'h08;
      if (s == 0 && mi == 0) exp_st |= 'h10;
      if (s == 0 && mi == 0 && h == 0) exp_st |= 'h20;
      rd(A_STAT, d);
      chk("R7 sweep event flags", d, exp_st);
      wr(A_STAT, 'h3C);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int y_list[1];
endmodule